// File: doc/BRIEF.md
# Single-Cycle Load/Store Datapath with Jump-and-Link

This block is a 32-bit processor core that completes one instruction on every clock edge. It holds a program counter, an instruction store, a 32-entry register file with two read ports and one write port, an ALU, a sign extender and a data store. Control comes from a small decoder that sorts each instruction into a class: register ALU, immediate ALU, load word, store word, jump-and-link, or unrecognised.

Jump-and-link is built from three pieces. A link path writes the return address PC+4 into register 31. A pseudo-direct target replaces the low 28 bits of the PC. There is no delay slot, so the instruction that follows a jump-and-link in memory is skipped.

Both stores are small internal word arrays. They are filled through dedicated load ports while reset is held. The ports that show register-file writes, data-store writes and the ALU zero flag let the surrounding logic observe every instruction as it retires.

Top module: `jal_datapath`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals `RESET_PC`, `rf_we_o` and `dm_we_o` are low, and every register is cleared, so a register read before any write after reset yields 0.
- R2: Opcode bits [31:26] = 6'b000000 is the register form. rd[15:11] receives rs[25:21] OP rt[20:16], where OP is bits [2:0]. The encodings are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed set-less-than, 6 shift left logical by b[4:0], 7 shift right logical by b[4:0].
- R3: Opcode 6'b001ooo is the immediate form. rt[20:16] receives rs OP sign-extended imm[15:0], where OP is opcode bits [2:0] with the R2 encodings.
- R4: Every instruction other than jump-and-link moves the PC to PC+4 on the next edge.
- R5: Load word (opcode 6'b100011) writes rt with the data word at rs + sign-extended imm.
- R6: Store word (opcode 6'b101011) writes rt to the data word at rs + sign-extended imm. It asserts `dm_we_o` and makes no register write.
- R7: Jump-and-link (opcode 6'b000011) writes PC+4 to register 31. The next PC is {PC[31:28], instr[25:0], 2'b00}. The instruction after it is not executed.
- R8: Register 0 always reads as zero. A write addressed to it has no effect.
- R9: `alu_zero_o` is high exactly when the ALU result is zero. For classes other than R2 and R3, the ALU adds rs and the sign-extended imm[15:0].
- R10: Any other opcode makes no register or memory write and advances the PC by 4.
- R11: The instruction store is indexed by PC bits [IW+1:2] and the data store by address bits [DW+1:2], with IW and DW their index widths, so addresses wrap modulo the store size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| im_ld_en | input | 1 | Instruction store preload strobe |
| im_ld_idx | input | IMEM_IW (6) | Instruction word index to preload |
| im_ld_data | input | 32 | Instruction word to preload |
| dm_ld_en | input | 1 | Data store preload strobe |
| dm_ld_idx | input | DMEM_IW (6) | Data word index to preload |
| dm_ld_data | input | 32 | Data word to preload |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Data store write this cycle |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Data being stored |
| alu_zero_o | output | 1 | ALU result is zero |

## Verification
The assertions check on every cycle that the PC advances by four after each non-jump instruction, and that a jump lands on the pseudo-direct target built from the previous PC. They also check that a store never coincides with a register write, that a register written in one cycle reads back its new value in the next, and that the decoder never raises two classes at once. The remaining behaviours can be shown only by the bench's instruction sequence: the arithmetic results, the effect of loads and stores, the skipped instruction after a jump, the ignored write to register 0, the cleared registers after reset and the wrap of data addresses.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(31);

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [2:0] OPC_IMM_HI = 3'b001;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_JAL   = 6'b000011;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_SLT = 3'd5,
        ALU_SLL = 3'd6,
        ALU_SRL = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    is_rtype;
        logic    is_itype;
        logic    is_load;
        logic    is_store;
        logic    is_jal;
        logic    reg_we;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/jdp_decode.sv
module jdp_decode
    import jdp_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [5:0] opc;
    assign opc = instr[31:26];

    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_ADD;
        if (opc == OPC_RTYPE) begin
            ctrl.is_rtype = 1'b1;
            ctrl.alu_op   = alu_op_e'(instr[2:0]);
        end else if (opc[5:3] == OPC_IMM_HI) begin
            ctrl.is_itype = 1'b1;
            ctrl.alu_op   = alu_op_e'(opc[2:0]);
        end else if (opc == OPC_LOAD) begin
            ctrl.is_load  = 1'b1;
        end else if (opc == OPC_STORE) begin
            ctrl.is_store = 1'b1;
        end else if (opc == OPC_JAL) begin
            ctrl.is_jal   = 1'b1;
        end
        ctrl.reg_we = ctrl.is_rtype | ctrl.is_itype | ctrl.is_load | ctrl.is_jal;
    end

    // Class signals are mutually exclusive (R10 relies on none being set)
    always_comb begin
        assert_class_onehot_R10: assert ($onehot0({ctrl.is_rtype, ctrl.is_itype,
                                                   ctrl.is_load, ctrl.is_store, ctrl.is_jal}));
    end

endmodule

// File: rtl/jdp_alu.sv
module jdp_alu
    import jdp_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_XOR: res = a ^ b;
            ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL: res = a << b[4:0];
            ALU_SRL: res = a >> b[4:0];
            default: res = '0;
        endcase
        zero = (res == '0);
    end

endmodule

// File: rtl/jdp_regfile.sv
module jdp_regfile
    import jdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra1,
    input  logic [RIDX_W-1:0] ra2,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && wa != '0) begin
            regs_d[wa] = wd;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

    // A value written to a nonzero register is what port 1 returns next cycle
    assert_wr_then_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> ((ra1 != $past(wa)) || (rd1 == $past(wd))));

endmodule

// File: rtl/jdp_mem.sv
module jdp_mem
    import jdp_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            ld_en,
    input  logic [IW-1:0]   ld_idx,
    input  logic [XLEN-1:0] ld_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data
);

    logic [XLEN-1:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            words_q[ld_idx] <= ld_data;
        end else if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_idx];

endmodule

// File: rtl/jal_datapath.sv
module jal_datapath
    import jdp_pkg::*;
#(
    parameter logic [31:0] RESET_PC   = 32'h0000_0000,
    parameter int          IMEM_WORDS = 64,
    parameter int          DMEM_WORDS = 64,
    localparam int         IMEM_IW    = $clog2(IMEM_WORDS),
    localparam int         DMEM_IW    = $clog2(DMEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               im_ld_en,
    input  logic [IMEM_IW-1:0] im_ld_idx,
    input  logic [31:0]        im_ld_data,
    input  logic               dm_ld_en,
    input  logic [DMEM_IW-1:0] dm_ld_idx,
    input  logic [31:0]        dm_ld_data,
    output logic [31:0]        pc_o,
    output logic               rf_we_o,
    output logic [4:0]         rf_waddr_o,
    output logic [31:0]        rf_wdata_o,
    output logic               dm_we_o,
    output logic [31:0]        dm_addr_o,
    output logic [31:0]        dm_wdata_o,
    output logic               alu_zero_o
);

    core_state_t state_d, state_q;

    logic [XLEN-1:0]   instr;
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
    logic [XLEN-1:0]   rs_val, rt_val;
    logic [XLEN-1:0]   imm_sext, alu_b, alu_res;
    logic              alu_zero;
    logic [XLEN-1:0]   pc_seq, jal_target;
    logic [XLEN-1:0]   dm_rdata;
    logic              rf_we, dm_we;
    logic [RIDX_W-1:0] wb_addr;
    logic [XLEN-1:0]   wb_data;

    jdp_mem #(.WORDS(IMEM_WORDS)) u_imem (
        .clk     (clk),
        .ld_en   (im_ld_en),
        .ld_idx  (im_ld_idx),
        .ld_data (im_ld_data),
        .wr_en   (1'b0),
        .wr_idx  ('0),
        .wr_data ('0),
        .rd_idx  (state_q.pc[IMEM_IW+1:2]),
        .rd_data (instr)
    );

    jdp_decode u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    assign rs_idx   = instr[25:21];
    assign rt_idx   = instr[20:16];
    assign rd_idx   = instr[15:11];
    assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    assign rf_we = ctrl.reg_we & rst_n;
    assign dm_we = ctrl.is_store & rst_n;

    always_comb begin
        if (ctrl.is_jal)        wb_addr = LINK_REG;
        else if (ctrl.is_rtype) wb_addr = rd_idx;
        else                    wb_addr = rt_idx;
    end

    jdp_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs_idx),
        .ra2   (rt_idx),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (rf_we),
        .wa    (wb_addr),
        .wd    (wb_data)
    );

    assign alu_b = ctrl.is_rtype ? rt_val : imm_sext;

    jdp_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .res  (alu_res),
        .zero (alu_zero)
    );

    jdp_mem #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk     (clk),
        .ld_en   (dm_ld_en),
        .ld_idx  (dm_ld_idx),
        .ld_data (dm_ld_data),
        .wr_en   (dm_we),
        .wr_idx  (alu_res[DMEM_IW+1:2]),
        .wr_data (rt_val),
        .rd_idx  (alu_res[DMEM_IW+1:2]),
        .rd_data (dm_rdata)
    );

    assign pc_seq     = state_q.pc + 32'd4;
    assign jal_target = {state_q.pc[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jal)       wb_data = pc_seq;
        else if (ctrl.is_load) wb_data = dm_rdata;
        else                   wb_data = alu_res;
    end

    always_comb begin
        state_d    = state_q;
        state_d.pc = ctrl.is_jal ? jal_target : pc_seq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = wb_addr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_res;
    assign dm_wdata_o = rt_val;
    assign alu_zero_o = alu_zero;

    assert_seq_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.is_jal |=> state_q.pc == $past(state_q.pc) + 32'd4);

    assert_jal_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_jal |=> state_q.pc == {$past(state_q.pc[31:28]), $past(instr[25:0]), 2'b00});

    assert_store_no_rf_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o);

endmodule

// File: tb/jal_datapath_bench.sv
module jal_datapath_bench;

    localparam logic [31:0] RST_PC = 32'h3000_0000;
    localparam int IW = 6;
    localparam int DW = 6;
    localparam int NW = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          im_ld_en = 1'b0, dm_ld_en = 1'b0;
    logic [IW-1:0] im_ld_idx = '0;
    logic [DW-1:0] dm_ld_idx = '0;
    logic [31:0]   im_ld_data = '0, dm_ld_data = '0;
    logic [31:0]   pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]    rf_waddr_o;
    logic          rf_we_o, dm_we_o, alu_zero_o;

    always #2 clk = ~clk;

    jal_datapath #(.RESET_PC(RST_PC), .IMEM_WORDS(NW), .DMEM_WORDS(1 << DW)) u_jal_datapath (
        .clk(clk), .rst_n(rst_n),
        .im_ld_en(im_ld_en), .im_ld_idx(im_ld_idx), .im_ld_data(im_ld_data),
        .dm_ld_en(dm_ld_en), .dm_ld_idx(dm_ld_idx), .dm_ld_data(dm_ld_data),
        .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o),
        .alu_zero_o(alu_zero_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_rf [32];
    logic [31:0] m_im [NW];
    logic [31:0] m_dm [1 << DW];
    string       tagv [NW];
    logic [31:0] m_pc;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int op, input int rd, input int rs, input int rt);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 8'd0, 3'(op)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rt, input int rs, input int imm);
        return {3'b001, 3'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_m(input logic [5:0] opc, input int rt, input int rs, input int imm);
        return {opc, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int widx);
        return {6'b000011, 26'(widx)};
    endfunction

    function automatic logic [31:0] m_alu(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6: return a << b[4:0];
            default: return a >> b[4:0];
        endcase
    endfunction

    // Compare this cycle's outputs with the model, then advance the model one instruction.
    task automatic step_and_compare();
        int idx, rs, rt, rd, op;
        logic [31:0] ins, a, b, sx, res, nxt;
        logic [5:0] opc;
        logic ew, ed;
        int wa;
        logic [31:0] wd;
        string t;
        idx = int'((m_pc >> 2) % NW);
        ins = m_im[idx];
        t   = tagv[idx];
        opc = ins[31:26];
        rs  = int'(ins[25:21]);
        rt  = int'(ins[20:16]);
        rd  = int'(ins[15:11]);
        sx  = {{16{ins[15]}}, ins[15:0]};
        a   = (rs == 0) ? 32'd0 : m_rf[rs];
        ew = 1'b0; ed = 1'b0; wa = 0; wd = '0;
        nxt = m_pc + 4;
        if (opc == 6'b000000) begin
            op = int'(ins[2:0]);
            b = (rt == 0) ? 32'd0 : m_rf[rt];
            res = m_alu(op, a, b);
            ew = 1'b1; wa = rd; wd = res;
        end else if (opc[5:3] == 3'b001) begin
            res = m_alu(int'(opc[2:0]), a, sx);
            ew = 1'b1; wa = rt; wd = res;
        end else begin
            res = a + sx;
            if (opc == 6'b100011) begin
                ew = 1'b1; wa = rt; wd = m_dm[(res >> 2) % (1 << DW)];
            end else if (opc == 6'b101011) begin
                ed = 1'b1;
            end else if (opc == 6'b000011) begin
                ew = 1'b1; wa = 31; wd = m_pc + 4;
                nxt = {m_pc[31:28], ins[25:0], 2'b00};
            end
        end
        chk(t, "pc", pc_o, m_pc);
        chk(t, "rf_we", 32'(rf_we_o), 32'(ew));
        if (ew) begin
            chk(t, "rf_waddr", 32'(rf_waddr_o), 32'(wa));
            chk(t, "rf_wdata", rf_wdata_o, wd);
        end
        chk(t, "dm_we", 32'(dm_we_o), 32'(ed));
        if (ed) begin
            chk(t, "dm_addr", dm_addr_o, res);
            chk(t, "dm_wdata", dm_wdata_o, (rt == 0) ? 32'd0 : m_rf[rt]);
        end
        chk("R9", "alu_zero", 32'(alu_zero_o), 32'(res == 32'd0));
        // model state update (R8: register 0 stays zero)
        if (ew && wa != 0) m_rf[wa] = wd;
        if (ed) m_dm[(res >> 2) % (1 << DW)] = (rt == 0) ? 32'd0 : m_rf[rt];
        m_pc = nxt;
    endtask

    task automatic put(input int i, input logic [31:0] w, input string t);
        m_im[i] = w;
        tagv[i] = t;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_im[i] = enc_r(0, 0, 0, 0);
            tagv[i] = "R8";
        end
        for (int i = 0; i < (1 << DW); i++) m_dm[i] = 32'h1000_0000 + 32'(i * 17);
        m_dm[1] = 32'h1234_5678;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;

        put(0,  enc_i(0, 1, 0, 5),       "R3");
        put(1,  enc_i(0, 2, 0, -3),      "R3");
        put(2,  enc_r(0, 3, 1, 2),       "R2");
        put(3,  enc_r(1, 4, 2, 1),       "R2");
        put(4,  enc_r(2, 5, 1, 2),       "R2");
        put(5,  enc_r(3, 6, 1, 2),       "R2");
        put(6,  enc_r(4, 7, 1, 2),       "R2");
        put(7,  enc_r(5, 8, 2, 1),       "R2");
        put(8,  enc_r(6, 9, 1, 1),       "R2");
        put(9,  enc_r(7, 10, 2, 1),      "R2");
        put(10, enc_r(1, 11, 1, 1),      "R2");
        put(11, enc_i(0, 0, 1, 7),       "R8");
        put(12, enc_r(0, 12, 0, 0),      "R8");
        put(13, enc_m(6'b101011, 3, 0, 8),  "R6");
        put(14, enc_m(6'b100011, 13, 0, 8), "R5");
        put(15, enc_m(6'b100011, 14, 0, 4), "R5");
        put(16, enc_i(4, 15, 14, 16'h0f0f), "R3");
        put(17, enc_j(20),                   "R7");
        put(18, enc_i(0, 16, 0, 99),         "R7");
        put(19, enc_i(0, 17, 0, 99),         "R7");
        put(20, enc_m(6'b101011, 31, 0, 60), "R6");
        put(21, 32'hFC00_1234,               "R10");
        put(22, enc_i(5, 18, 2, -2),         "R3");
        put(23, enc_m(6'b101011, 2, 0, 256), "R11");
        put(24, enc_m(6'b100011, 19, 0, 0),  "R11");
        put(25, enc_r(0, 20, 21, 22),        "R1");
        put(26, enc_r(0, 23, 16, 17),        "R7");
        put(27, enc_j(2),                    "R7");

        // preload while reset is held
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            im_ld_en = 1'b1; im_ld_idx = IW'(i); im_ld_data = m_im[i];
            dm_ld_en = 1'b1; dm_ld_idx = DW'(i); dm_ld_data = m_dm[i];
        end
        @(negedge clk);
        im_ld_en = 1'b0; dm_ld_en = 1'b0;
        #1;
        chk("R1", "pc in reset", pc_o, RST_PC);
        chk("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
        chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);

        m_pc = RST_PC;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        step_and_compare();
        for (int c = 0; c < 90; c++) begin
            @(negedge clk);
            #1;
            step_and_compare();
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule